// File: doc/BRIEF.md
# MDIO Management Command Engine

This block is a management-interface master that turns a single 32-bit command word into one clause-22 MDIO transaction toward an external PHY. Software first writes the operation code, PHY address, register address and (for a write) the 16-bit payload. It then launches the transaction with a later write that sets the start/busy bit. While the frame runs, the engine generates MDC from the system clock through a parameterised divider and drives the shared data line. The data line is split into output, output-enable and input pins, so the pad and its pull-up can sit outside the block.

When the frame ends, the busy bit drops. For a read, the low half of the same word then holds the data returned by the PHY. If the PHY fails to pull the line low in the second turnaround slot, a failure flag is set and the returned data is forced to all-ones. Software polls the word until busy is clear.

Top module: `mdio_cmd_engine`

## Requirements
- R1: After reset the command word reads 0. A write while idle stores bits 27:0 and bit 29. Bit 28 is a status bit and software cannot write it. Bits 31:30 always read 0.
- R2: A write with bit 29 set while idle launches a transaction. Bit 29 reads 1 from the next cycle until the frame has ended and then returns to 0 by itself.
- R3: A frame is 64 MDC periods, sent MSB first: 32 ones, start pattern 01, op code (bits 27:26), PHY address (bits 25:21), register address (bits 20:16), two turnaround slots, then 16 data bits. On a write the turnaround slots are 1 then 0 and the data bits are word bits 15:0.
- R4: On a read (op code 2'b10), the output enable is high for the first 46 bit slots and low for the last 18. On any other op code, the output enable is high for all 64 slots.
- R5: When a read ends with the turnaround answered, bits 15:0 hold the 16 bits sampled in the data slots, MSB first, and bit 28 is 0. Bits 27:16 keep their written values.
- R6: If the input is high when sampled in the second turnaround slot of a read, bit 28 is set and bits 15:0 become 16'hFFFF when the frame ends. Each new launch clears bit 28.
- R7: MDC has a period of 2*DIV_HALF system clocks during a frame and is low whenever the engine is idle. The output enable is low whenever the engine is idle.
- R8: The MDIO output changes only on the system clock edge at which MDC falls. The input is sampled on the edge at which MDC rises.
- R9: A write to the command word while bit 29 is set has no effect on the word or on the frame in progress.
- R10: Op codes other than 2'b10 (including 2'b00 and 2'b11) are framed like a write, with the op field sent exactly as written.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | System clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| reg_we_i | input | 1 | Command word write strobe |
| reg_wdata_i | input | 32 | Command word write data |
| reg_rdata_o | output | 32 | Command word read value |
| mdc_o | output | 1 | Management clock to the PHY |
| mdio_o | output | 1 | Management data out |
| mdio_oe_o | output | 1 | Management data output enable |
| mdio_i | input | 1 | Management data in |

## Verification
The hardest situation to reach from the ports is the exact interplay at the turnaround. The PHY must release, then pull low in precisely the second slot, and its data must appear only after the MDC falling edge ahead of each sampled slot. To get there, the bench behaves as a PHY: it counts MDC rising edges and updates its response one half period ahead of each sample. Both a present PHY and an absent one are exercised this way. A write-while-busy is also injected in the middle of a frame, and the captured frame is then compared bit by bit with the one originally launched.

// File: rtl/mdio_pkg.sv
package mdio_pkg;
  localparam int PRE_LEN   = 32;
  localparam int FRAME_LEN = 64;
  localparam int CNT_W     = $clog2(FRAME_LEN + 1);
  localparam int REL_IDX   = PRE_LEN + 14;   // first turnaround slot
  localparam int TA2_IDX   = REL_IDX + 1;    // slot where PHY must drive 0
  localparam int DATA_IDX  = REL_IDX + 2;

  localparam int B_BUSY = 29;
  localparam int B_FAIL = 28;

  localparam logic [1:0] OP_RD = 2'b10;
  localparam logic [1:0] OP_WR = 2'b01;
endpackage

// File: rtl/mdio_mdc_gen.sv
module mdio_mdc_gen #(
  parameter int DIV_HALF = 4
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic run_i,
  output logic mdc_o,
  output logic rise_o,
  output logic fall_o
);
  localparam int CW = $clog2(DIV_HALF + 1);

  logic [CW-1:0] cnt_q;
  logic          mdc_q;
  logic          tick;

  assign tick   = run_i && (cnt_q == CW'(DIV_HALF - 1));
  assign rise_o = tick && !mdc_q;
  assign fall_o = tick && mdc_q;
  assign mdc_o  = mdc_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      cnt_q <= '0;
      mdc_q <= 1'b0;
    end else if (!run_i) begin
      cnt_q <= '0;
      mdc_q <= 1'b0;
    end else if (tick) begin
      cnt_q <= '0;
      mdc_q <= ~mdc_q;
    end else begin
      cnt_q <= cnt_q + 1'b1;
    end
  end

  AST_MDC_RISE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    rise_o |=> mdc_o);  // R7
  AST_MDC_STOP: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !run_i |=> !mdc_o);  // R7
endmodule

// File: rtl/mdio_frame.sv
module mdio_frame
  import mdio_pkg::*;
(
  input  logic        clk_i,
  input  logic        rst_ni,
  input  logic        start_i,
  input  logic [1:0]  op_i,
  input  logic [4:0]  phy_i,
  input  logic [4:0]  reg_i,
  input  logic [15:0] wdata_i,
  input  logic        rise_i,
  input  logic        fall_i,
  input  logic        mdio_i,
  output logic        active_o,
  output logic        mdio_o,
  output logic        mdio_oe_o,
  output logic        done_o,
  output logic        fail_o,
  output logic [15:0] rdata_o
);
  logic [FRAME_LEN-1:0] sh_q;
  logic [FRAME_LEN-1:0] frame;
  logic [CNT_W-1:0]     cnt_q;
  logic                 active_q, rd_q, ta_ok_q, done_q, fail_q;
  logic [15:0]          cap_q, rdata_q;
  logic                 rd_new;

  assign rd_new = (op_i == OP_RD);
  assign frame  = {{PRE_LEN{1'b1}}, 2'b01, op_i, phy_i, reg_i,
                   (rd_new ? 2'b11 : 2'b10), (rd_new ? 16'hFFFF : wdata_i)};

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      sh_q     <= '0;
      cnt_q    <= '0;
      active_q <= 1'b0;
      rd_q     <= 1'b0;
      ta_ok_q  <= 1'b0;
      cap_q    <= '0;
      done_q   <= 1'b0;
      fail_q   <= 1'b0;
      rdata_q  <= '0;
    end else if (start_i) begin
      sh_q     <= frame;
      cnt_q    <= '0;
      active_q <= 1'b1;
      rd_q     <= rd_new;
      ta_ok_q  <= 1'b0;
      cap_q    <= '0;
      done_q   <= 1'b0;
    end else begin
      done_q <= 1'b0;
      if (active_q && rise_i && rd_q) begin
        if (cnt_q == CNT_W'(TA2_IDX)) ta_ok_q <= !mdio_i;
        if (cnt_q >= CNT_W'(DATA_IDX)) cap_q <= {cap_q[14:0], mdio_i};
      end
      if (active_q && fall_i) begin
        sh_q  <= sh_q << 1;
        cnt_q <= cnt_q + 1'b1;
        if (cnt_q == CNT_W'(FRAME_LEN - 1)) begin
          active_q <= 1'b0;
          done_q   <= 1'b1;
          fail_q   <= rd_q && !ta_ok_q;
          rdata_q  <= (rd_q && !ta_ok_q) ? 16'hFFFF : cap_q;
        end
      end
    end
  end

  assign active_o  = active_q;
  assign mdio_o    = active_q ? sh_q[FRAME_LEN-1] : 1'b1;
  assign mdio_oe_o = active_q && (!rd_q || (cnt_q < CNT_W'(REL_IDX)));
  assign done_o    = done_q;
  assign fail_o    = fail_q;
  assign rdata_o   = rdata_q;

  AST_EDGE_EXCL: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !(rise_i && fall_i));  // R8
  AST_MDIO_HOLD: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (active_q && $past(active_q) && !$past(fall_i) && !$past(start_i))
      |-> $stable(mdio_o));  // R8
endmodule

// File: rtl/mdio_cmd_engine.sv
module mdio_cmd_engine
  import mdio_pkg::*;
#(
  parameter int DIV_HALF = 4
) (
  input  logic        clk_i,
  input  logic        rst_ni,
  input  logic        reg_we_i,
  input  logic [31:0] reg_wdata_i,
  output logic [31:0] reg_rdata_o,
  output logic        mdc_o,
  output logic        mdio_o,
  output logic        mdio_oe_o,
  input  logic        mdio_i
);
  logic [29:0] cmd_q;
  logic        busy, launch;
  logic        active, rise, fall, done, fail;
  logic [15:0] rdata;

  assign busy   = cmd_q[B_BUSY];
  assign launch = reg_we_i && !busy && reg_wdata_i[B_BUSY];

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      cmd_q <= '0;
    end else if (reg_we_i && !busy) begin
      cmd_q[27:0]   <= reg_wdata_i[27:0];
      cmd_q[B_BUSY] <= reg_wdata_i[B_BUSY];
      if (reg_wdata_i[B_BUSY]) cmd_q[B_FAIL] <= 1'b0;
    end else if (done) begin
      cmd_q[B_BUSY] <= 1'b0;
      cmd_q[B_FAIL] <= fail;
      if (cmd_q[27:26] == OP_RD) cmd_q[15:0] <= rdata;
    end
  end

  assign reg_rdata_o = {2'b00, cmd_q};

  mdio_mdc_gen #(.DIV_HALF(DIV_HALF)) u_mdc (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .run_i  (active),
    .mdc_o  (mdc_o),
    .rise_o (rise),
    .fall_o (fall)
  );

  mdio_frame u_frame (
    .clk_i     (clk_i),
    .rst_ni    (rst_ni),
    .start_i   (launch),
    .op_i      (reg_wdata_i[27:26]),
    .phy_i     (reg_wdata_i[25:21]),
    .reg_i     (reg_wdata_i[20:16]),
    .wdata_i   (reg_wdata_i[15:0]),
    .rise_i    (rise),
    .fall_i    (fall),
    .mdio_i    (mdio_i),
    .active_o  (active),
    .mdio_o    (mdio_o),
    .mdio_oe_o (mdio_oe_o),
    .done_o    (done),
    .fail_o    (fail),
    .rdata_o   (rdata)
  );

  AST_LAUNCH_BUSY: assert property (@(posedge clk_i) disable iff (!rst_ni)
    launch |=> busy);  // R2
  AST_IDLE_QUIET: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !busy |-> (!mdio_oe_o && !mdc_o));  // R7
  AST_BUSY_IGNORE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (busy && reg_we_i) |=> (cmd_q[27:16] == $past(cmd_q[27:16])));  // R9
  AST_FAIL_ONES: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ($fell(busy) && cmd_q[B_FAIL]) |-> (cmd_q[15:0] == 16'hFFFF));  // R6
endmodule

// File: tb/tb_mdio_cmd_engine.sv
module tb_mdio_cmd_engine;
  localparam int CLK_PERIOD = 10;
  localparam int DIV_HALF   = 2;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        we = 1'b0;
  logic [31:0] wdata = '0;
  logic [31:0] rdata;
  logic        mdc, mdo, moe, mdi;

  logic        phy_drv = 1'b1;
  logic        phy_present = 1'b1;
  logic [15:0] phy_data = '0;

  int          n_tests = 0;
  int          n_fail = 0;
  logic [63:0] got_bits, got_oe;
  int          rises, cyc, last_rise, bad_period, bad_edge;
  logic        mdc_prev = 1'b0, mdo_prev = 1'b1;
  logic        done_flag = 1'b0;

  always #(CLK_PERIOD/2) clk = ~clk;

  assign mdi = moe ? mdo : phy_drv;

  mdio_cmd_engine #(.DIV_HALF(DIV_HALF)) dut (
    .clk_i(clk), .rst_ni(rst_n), .reg_we_i(we), .reg_wdata_i(wdata),
    .reg_rdata_o(rdata), .mdc_o(mdc), .mdio_o(mdo), .mdio_oe_o(moe), .mdio_i(mdi)
  );

  function automatic logic resp(int n);
    if (n == 47) return !phy_present;
    if (n >= 48 && n < 64 && phy_present) return phy_data[63-n];
    return 1'b1;
  endfunction

  // PHY model and pin monitor
  always @(negedge clk) begin
    cyc = cyc + 1;
    if (mdc && !mdc_prev) begin
      if (rises < 64) begin
        got_bits[63-rises] = mdo;
        got_oe[63-rises]   = moe;
      end
      if (rises > 0 && (cyc - last_rise) != 2*DIV_HALF) bad_period = bad_period + 1;
      last_rise = cyc;
      rises = rises + 1;
    end
    if (!mdc && mdc_prev) phy_drv = resp(rises);
    if (mdo != mdo_prev && !(!mdc && mdc_prev)) bad_edge = bad_edge + 1;
    mdc_prev = mdc;
    mdo_prev = mdo;
  end

  task automatic chk(input logic ok, input string tag, input logic [63:0] act, input logic [63:0] exp);
    n_tests++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  task automatic write_reg(input logic [31:0] w);
    @(negedge clk);
    we = 1'b1; wdata = w;
    @(negedge clk);
    we = 1'b0;
  endtask

  task automatic clear_mon();
    rises = 0; bad_period = 0; bad_edge = 0; got_bits = '0; got_oe = '0;
    phy_drv = 1'b1; cyc = 0; last_rise = 0;
  endtask

  task automatic wait_idle();
    int k;
    k = 0;
    while (rdata[29] && k < 2000) begin @(negedge clk); k++; end
    chk(k < 2000, "R2 busy timeout", 64'(k), 64'd0);
  endtask

  task automatic run_txn(input logic [31:0] w);
    write_reg(w & ~(32'h1 << 29));
    clear_mon();
    write_reg(w | (32'h1 << 29));
    chk(rdata[29] == 1'b1, "R2 busy after launch", 64'(rdata[29]), 64'd1);
    wait_idle();
  endtask

  function automatic logic [31:0] mk(logic [1:0] op, logic [4:0] p, logic [4:0] r, logic [15:0] d);
    return {4'b0000, op, p, r, d};
  endfunction

  initial begin
    #(CLK_PERIOD*150000);
    n_fail++;
    $display("FAIL watchdog actual=running expected=done");
    if (!done_flag) $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  end

  initial begin
    logic [31:0] w;
    logic [63:0] exp_f;
    logic [45:0] exp_h;
    clear_mon();
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    // R1, R7 reset state
    chk(rdata == 32'h0, "R1 reset value", 64'(rdata), 64'h0);
    chk(!mdc && !moe, "R7 idle pins", {62'd0, mdc, moe}, 64'd0);

    // R1 readback: bit 28 not writable, 31:30 read zero
    write_reg(32'hDFFF_FFFF);
    chk(rdata == 32'h0FFF_FFFF, "R1 field readback", 64'(rdata), 64'h0FFF_FFFF);
    chk(!mdc && !moe, "R7 idle after plain write", {62'd0, mdc, moe}, 64'd0);

    // R3 R4 R7 R8: write frame sweep
    foreach (phy_list[i]) ;
    for (int p = 0; p < 32; p += 7) begin
      for (int r = 0; r < 32; r += 13) begin
        logic [15:0] d;
        d = 16'((p * 2311 + r * 97) ^ 16'hA5C3);
        w = mk(2'b01, 5'(p), 5'(r), d);
        run_txn(w);
        exp_f = {32'hFFFF_FFFF, 2'b01, 2'b01, 5'(p), 5'(r), 2'b10, d};
        chk(got_bits == exp_f, "R3 write frame", got_bits, exp_f);
        chk(got_oe == {64{1'b1}}, "R4 write drive", got_oe, {64{1'b1}});
        chk(rises == 64, "R3 frame length", 64'(rises), 64'd64);
        chk(bad_period == 0, "R7 mdc period", 64'(bad_period), 64'd0);
        chk(bad_edge == 0, "R8 change on fall", 64'(bad_edge), 64'd0);
        chk(rdata == w, "R2 word after write", 64'(rdata), 64'(w));
        chk(!mdc && !moe, "R7 idle after frame", {62'd0, mdc, moe}, 64'd0);
      end
    end

    // R4 R5 reads with PHY present
    phy_present = 1'b1;
    for (int k = 0; k < 6; k++) begin
      logic [15:0] pd;
      logic [4:0] p, r;
      pd = (k == 0) ? 16'h0000 : (k == 1) ? 16'hFFFF : (k == 2) ? 16'h8001 : 16'(k * 16'h3B29 + 16'h0417);
      p = 5'(k * 5 + 1); r = 5'(31 - k * 3);
      phy_data = pd;
      w = mk(2'b10, p, r, 16'h1234);
      run_txn(w);
      exp_h = {32'hFFFF_FFFF, 2'b01, 2'b10, p, r};
      chk(got_bits[63:18] == exp_h, "R3 read header", 64'(got_bits[63:18]), 64'(exp_h));
      chk(got_oe == {{46{1'b1}}, 18'd0}, "R4 read release", got_oe, {{46{1'b1}}, 18'd0});
      chk(rdata == {4'b0000, 2'b10, p, r, pd}, "R5 read data", 64'(rdata), 64'({4'b0000, 2'b10, p, r, pd}));
      chk(bad_edge == 0, "R8 read edges", 64'(bad_edge), 64'd0);
    end

    // R6 absent PHY, then recovery clears flag
    phy_present = 1'b0;
    w = mk(2'b10, 5'd9, 5'd2, 16'h0000);
    run_txn(w);
    chk(rdata == {4'b0001, 2'b10, 5'd9, 5'd2, 16'hFFFF}, "R6 no answer", 64'(rdata),
        64'({4'b0001, 2'b10, 5'd9, 5'd2, 16'hFFFF}));
    phy_present = 1'b1; phy_data = 16'h5A5A;
    run_txn(w);
    chk(rdata == {4'b0000, 2'b10, 5'd9, 5'd2, 16'h5A5A}, "R6 flag cleared", 64'(rdata),
        64'({4'b0000, 2'b10, 5'd9, 5'd2, 16'h5A5A}));

    // R10 other op codes framed as write
    for (int o = 0; o < 4; o += 3) begin
      w = mk(2'(o), 5'd17, 5'd4, 16'hC0DE);
      run_txn(w);
      exp_f = {32'hFFFF_FFFF, 2'b01, 2'(o), 5'd17, 5'd4, 2'b10, 16'hC0DE};
      chk(got_bits == exp_f, "R10 op framing", got_bits, exp_f);
      chk(got_oe == {64{1'b1}}, "R10 op drive", got_oe, {64{1'b1}});
    end

    // R9 write while busy ignored
    w = mk(2'b01, 5'd3, 5'd30, 16'h0F0F);
    write_reg(w);
    clear_mon();
    write_reg(w | (32'h1 << 29));
    repeat (20) @(negedge clk);
    write_reg(32'h2BFF_FFFF);
    chk(rdata[27:0] == w[27:0], "R9 fields kept", 64'(rdata), 64'(w | (32'h1 << 29)));
    chk(rdata[29] == 1'b1, "R9 still busy", 64'(rdata[29]), 64'd1);
    wait_idle();
    exp_f = {32'hFFFF_FFFF, 2'b01, 2'b01, 5'd3, 5'd30, 2'b10, 16'h0F0F};
    chk(got_bits == exp_f, "R9 frame unchanged", got_bits, exp_f);
    chk(rdata == w, "R9 word after", 64'(rdata), 64'(w));

    done_flag = 1'b1;
    $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  end

  int phy_list[1];
endmodule